// File: doc/BRIEF.md
# Nonvolatile Commit Sequencer

This block sits between a serial command decoder and a bank of nonvolatile data registers. The decoder hands it a store request. That request is either a direct data-register write carrying an address and a byte, or a wiper-to-register transfer carrying an address and the current wiper position. The sequencer holds the request as pending and does nothing more until chip select is released (rises) at the end of the frame.

On that release it samples the write-protect input. If protection is off, it starts a timed commit: the busy flag `wip` goes high and stays high for a programmable number of timebase ticks. When the last tick arrives, a one-cycle write strobe goes to the storage array together with the latched address and data, and `wip` drops. If protection is on when chip select rises, the pending request is thrown away. While a commit is running, any new store request is dropped, but `wip` can still be read at any time.

Top module: `nvs_commit_seq`

## Requirements
- R1: After reset, `wip` and `mem_we` are 0.
- R2: When a data-write request is pending, `wp_n` is 1 and `cs_n` is seen rising, `wip` reads 1 from the next clock cycle onward.
- R3: `wip` stays 1 until exactly `WR_TICKS` cycles with `tick`=1 have occurred. In the cycle where `wip` returns to 0, `mem_we` is 1 for that single cycle, with `mem_addr`/`mem_data` carrying the committed address and byte.
- R4: A transfer request commits `wiper_pos` to `xfer_addr` through the same timed cycle.
- R5: If `wp_n` is 0 when `cs_n` rises, no commit starts: `wip` stays 0, no strobe is issued, and the pending request is discarded. A later `cs_n` rise alone does not commit it.
- R6: Write and transfer requests that arrive while `wip`=1 are ignored. A `cs_n` rise while busy neither restarts nor changes the running commit.
- R7: A `cs_n` rise with no pending request leaves `wip` at 0.
- R8: If a write request and a transfer request arrive in the same cycle, the write request wins.
- R9: A later request in the same frame replaces an earlier one.
- R10: `mem_addr` and `mem_data` stay unchanged while a commit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Data-register write request, one cycle |
| wr_addr | input | AW | Register address for the write request |
| wr_data | input | DW | Byte for the write request |
| xfer_req | input | 1 | Wiper-to-register transfer request, one cycle |
| xfer_addr | input | AW | Register address for the transfer |
| wiper_pos | input | DW | Current wiper position |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Write protect, low blocks commits |
| tick | input | 1 | Timebase pulse that counts the commit time |
| wip | output | 1 | Commit in progress |
| mem_we | output | 1 | One-cycle write strobe to the storage array |
| mem_addr | output | AW | Address of the committed register |
| mem_data | output | DW | Byte being committed |

## Verification
Some rules are checked by embedded properties on every cycle. The strobe may appear only as `wip` falls. A commit start must raise `wip` on the following cycle. A protected chip-select release must not start a commit. Nothing may become pending while busy. The tick counter must stay inside its range, and the committed address and data must hold steady while busy.

Other behaviour can only be shown by the directed scenarios. These cover the exact tick count of a commit, the committed values of the write and transfer paths, the priority between simultaneous requests, and the last-request-wins rule. They also show that a protected or busy-time request leaves nothing behind for a later chip-select release.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_WRITE = 2'd1,
    PICK_XFER  = 2'd2
  } nvs_pick_e;

  function automatic nvs_pick_e nvs_select(input logic wr_v, input logic xf_v);
    if (wr_v)      return PICK_WRITE;
    else if (xf_v) return PICK_XFER;
    else           return PICK_NONE;
  endfunction
endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nvs_req_latch.sv
module nvs_req_latch
  import nvs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          clear,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          xf_vld,
  input  logic [AW-1:0] xf_addr,
  input  logic [DW-1:0] wiper,
  output logic          pend_vld,
  output logic [AW-1:0] pend_addr,
  output logic [DW-1:0] pend_data
);
  nvs_pick_e     pick;
  logic          vld_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;
  logic          load_en;

  always_comb begin
    pick    = busy ? PICK_NONE : nvs_select(wr_vld, xf_vld);
    load_en = 1'b0;
    vld_d   = pend_vld;
    addr_d  = pend_addr;
    data_d  = pend_data;
    if (clear) begin
      vld_d = 1'b0;
    end else begin
      case (pick)
        PICK_WRITE: begin vld_d = 1'b1; load_en = 1'b1; addr_d = wr_addr; data_d = wr_data; end
        PICK_XFER:  begin vld_d = 1'b1; load_en = 1'b1; addr_d = xf_addr; data_d = wiper;   end
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_vld <= 1'b0;
    else        pend_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_data <= '0;
    end else if (load_en) begin
      pend_addr <= addr_d;
      pend_data <= data_d;
    end
  end

  // R6
  no_pend_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend_vld) |=> !pend_vld);
endmodule

// File: rtl/nvs_cycle_timer.sv
module nvs_cycle_timer #(
  parameter int WR_TICKS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WR_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WR_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    done_d = 1'b0;
    if (busy) begin
      if (tick) begin
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
      done  <= done_d;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R3
  strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/nvs_commit_seq.sv
module nvs_commit_seq #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int WR_TICKS = 50000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          xfer_req,
  input  logic [AW-1:0] xfer_addr,
  input  logic [DW-1:0] wiper_pos,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          tick,
  output logic          wip,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);
  logic          rst_sync_n;
  logic          cs_q;
  logic          cs_rise;
  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic          go;
  logic          busy;
  logic          done;

  nvs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cs_q <= 1'b1;
    else             cs_q <= cs_n;
  end

  assign cs_rise = cs_n && !cs_q;
  assign go      = cs_rise && pend_vld && wp_n && !busy;

  nvs_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy), .clear(cs_rise),
    .wr_vld(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .xf_vld(xfer_req), .xf_addr(xfer_addr), .wiper(wiper_pos),
    .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_data(pend_data)
  );

  nvs_cycle_timer #(.WR_TICKS(WR_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(go), .tick(tick),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_addr <= '0;
      mem_data <= '0;
    end else if (go) begin
      mem_addr <= pend_addr;
      mem_data <= pend_data;
    end
  end

  assign wip    = busy;
  assign mem_we = done;

  // R2
  start_raises_wip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go |=> wip);
  // R5
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_rise && !wp_n && !busy) |=> !wip);
  // R10
  commit_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wip && $past(wip)) |-> ($stable(mem_addr) && $stable(mem_data)));
  // R7
  no_pending_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_rise && !pend_vld && !busy) |=> !wip);
endmodule

// File: tb/nvs_commit_seq_tb.sv
`timescale 1ns/1ps
module nvs_commit_seq_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_req, xfer_req, cs_n, wp_n, tick;
  logic [AW-1:0] wr_addr, xfer_addr, mem_addr;
  logic [DW-1:0] wr_data, wiper_pos, mem_data;
  logic          wip, mem_we;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvs_commit_seq #(.AW(AW), .DW(DW), .WR_TICKS(WT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .wiper_pos(wiper_pos),
    .cs_n(cs_n), .wp_n(wp_n), .tick(tick), .wip(wip), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_req = 1'b1; wr_addr = a; wr_data = d; step(); wr_req = 1'b0;
  endtask

  task automatic issue_xf(input logic [AW-1:0] a, input logic [DW-1:0] w);
    xfer_req = 1'b1; xfer_addr = a; wiper_pos = w; step(); xfer_req = 1'b0;
  endtask

  task automatic frame_open();
    cs_n = 1'b0; step();
  endtask

  task automatic frame_close();
    cs_n = 1'b1; step();
  endtask

  task automatic finish_commit(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int i = 0; i < WT; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
      if (i < WT - 1) begin
        chk({tag, " wip held"}, wip, 1);
        chk({tag, " no early strobe"}, mem_we, 0);
      end else begin
        chk({tag, " R3 wip fall"}, wip, 0);
        chk({tag, " R3 strobe"}, mem_we, 1);
        chk({tag, " addr"}, mem_addr, a);
        chk({tag, " data"}, mem_data, d);
      end
    end
    step();
    chk({tag, " R3 strobe single"}, mem_we, 0);
  endtask

  task automatic t_reset();
    chk("R1 wip after reset", wip, 0);
    chk("R1 mem_we after reset", mem_we, 0);
  endtask

  task automatic t_write();
    frame_open(); issue_wr(4'h6, 8'hA5); frame_close();
    chk("R2 wip after cs rise", wip, 1);
    step(); step();
    chk("R3 no tick keeps wip", wip, 1);
    finish_commit("R2", 4'h6, 8'hA5);
  endtask

  task automatic t_xfer();
    frame_open(); issue_xf(4'h1, 8'h3C); frame_close();
    chk("R4 wip after cs rise", wip, 1);
    finish_commit("R4", 4'h1, 8'h3C);
  endtask

  task automatic t_protect();
    frame_open(); issue_wr(4'h9, 8'h77); wp_n = 1'b0; frame_close();
    chk("R5 protected no wip", wip, 0);
    tick = 1'b1; step(); step(); tick = 1'b0;
    chk("R5 protected no strobe", mem_we, 0);
    wp_n = 1'b1; frame_open(); frame_close();
    chk("R5 discarded request", wip, 0);
  endtask

  task automatic t_busy_ignore();
    frame_open(); issue_wr(4'h2, 8'h11); frame_close();
    chk("R6 wip started", wip, 1);
    frame_open(); issue_wr(4'hE, 8'hEE); issue_xf(4'hD, 8'hDD); frame_close();
    chk("R6 busy cs rise keeps wip", wip, 1);
    finish_commit("R6", 4'h2, 8'h11);
    frame_open(); frame_close();
    chk("R6 busy request dropped", wip, 0);
  endtask

  task automatic t_no_pending();
    frame_open(); frame_close();
    chk("R7 no pending no wip", wip, 0);
    step();
    chk("R7 no strobe", mem_we, 0);
  endtask

  task automatic t_both();
    frame_open();
    wr_req = 1'b1; wr_addr = 4'h2; wr_data = 8'hAA;
    xfer_req = 1'b1; xfer_addr = 4'h1; wiper_pos = 8'h55;
    step(); wr_req = 1'b0; xfer_req = 1'b0;
    frame_close();
    chk("R8 wip", wip, 1);
    finish_commit("R8", 4'h2, 8'hAA);
  endtask

  task automatic t_replace();
    frame_open(); issue_wr(4'h3, 8'h0B); issue_xf(4'h5, 8'h22); frame_close();
    chk("R9 wip", wip, 1);
    finish_commit("R9", 4'h5, 8'h22);
  endtask

  initial begin
    rst_n = 1'b0; wr_req = 0; xfer_req = 0; cs_n = 1; wp_n = 1; tick = 0;
    wr_addr = '0; wr_data = '0; xfer_addr = '0; wiper_pos = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    t_reset();
    t_write();
    t_xfer();
    t_protect();
    t_busy_ignore();
    t_no_pending();
    t_both();
    t_replace();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule